// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in, first-out buffer whose producer and consumer run on unrelated clocks. The producer pushes words on the write clock. The consumer pulls words on the read clock. Each pulled word is captured in an output register, and from that moment it no longer counts as stored. The default build holds 512 words of 36 bits.

Each side gets an early-warning flag from its own clock domain. The almost-empty flag belongs to the read side and the almost-full flag belongs to the write side. Each flag compares the fill level against an offset register that the owning domain can reprogram. The write and read pointers are binary counters. Each crosses into the opposite domain as Gray code through a two-stage synchronizer. As a result, a flag sees an event from the far side only after two edges of its own clock.

Exact full and empty indicators are also provided. A write while full and a read while empty are both dropped. A single active-low asynchronous reset clears both domains together.

Top module: `dcfifo_almost`

## Requirements
- R1: While and after reset: `empty_o`=1, `full_o`=0, `ae_n_o`=0, `af_n_o`=1, `rd_data_o`=0. Both offsets take their default parameter values (8).
- R2: Words leave in the order they were accepted. `rd_data_o` takes the next word on the read-clock edge where `rd_en_i`=1 and `empty_o`=0.
- R3: `full_o`=1 when the write side sees DEPTH words stored. A write while `full_o`=1 is dropped and never appears at the output.
- R4: `empty_o`=1 when the read side sees no word stored. A read while `empty_o`=1 leaves `rd_data_o` and the fill level unchanged.
- R5: `ae_n_o` (active low) is 0 when the read side's count is X or fewer and 1 when it is X+1 or more. X is the almost-empty offset. A word in the output register is not counted, so a read that brings the count to X drives `ae_n_o` low after that same read edge.
- R6: `af_n_o` (active low) is 0 when the write side's count is DEPTH−Y or more and 1 when it is DEPTH−Y−1 or fewer. Y is the almost-full offset.
- R7: After a write that raises the count from X to X+1, `ae_n_o` stays 0 following the first rising read-clock edge. It becomes 1 following the second.
- R8: After a read that lowers the count from DEPTH−Y to DEPTH−Y−1, `af_n_o` stays 0 following the first rising write-clock edge. It becomes 1 following the second.
- R9: On a read-clock edge with `ae_ld_i`=1, X takes `ae_off_i`. On a write-clock edge with `af_ld_i`=1, Y takes `af_off_i`. Without loads both stay at their defaults, and the flags follow the new values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | DW | Word to push |
| full_o | output | 1 | Buffer full (write domain) |
| af_n_o | output | 1 | Almost full, active low (write domain) |
| af_ld_i | input | 1 | Load almost-full offset (write domain) |
| af_off_i | input | AW | New almost-full offset |
| rd_en_i | input | 1 | Pull request |
| rd_data_o | output | DW | Output register |
| empty_o | output | 1 | Buffer empty (read domain) |
| ae_n_o | output | 1 | Almost empty, active low (read domain) |
| ae_ld_i | input | 1 | Load almost-empty offset (read domain) |
| ae_off_i | input | AW | New almost-empty offset |

## Verification
The bench builds the block with AW=5, a 32-word buffer of 36-bit words, and default offsets of 8. This small depth lets random traffic fill the buffer to full and drain it to empty many times. It also wraps both pointers through every Gray code and their extra lap bit within a few thousand cycles. With 32 words, offsets of 0 and 31 are extremes that a few writes can reach, so each flag's threshold can sit on the full or empty boundary itself.

The two clocks run at 5 ns and 7 ns with edges that never coincide. This makes the two-edge flag latency after a far-side event deterministic, so it can be checked edge by edge.

// File: rtl/dcf_pkg.sv
`timescale 1ns/100ps
package dcf_pkg;
  function automatic logic [31:0] gray_enc(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_dec(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/100ps
module dcf_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/100ps
module dcf_mem #(
  parameter int AW = 9,
  parameter int DW = 36
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] q_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register: a word captured here has left the buffer
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (re_i) q_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/100ps
module dcf_wr_ctl #(
  parameter int AW     = 9,
  parameter int AF_DEF = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [AW:0] rgray_i,
  input  logic        af_ld_i,
  input  logic [AW-1:0] af_off_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        wr_fire_o,
  output logic        full_o,
  output logic        af_n_o
);
  import dcf_pkg::*;

  localparam int PW    = AW + 1;
  localparam int CW    = AW + 2;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_nx, rbin_s, wcnt;
  logic [AW-1:0] yoff_q;

  assign rbin_s    = PW'(gray_dec(32'(rgray_i)));
  assign wcnt      = wbin_q - rbin_s;
  assign full_o    = (wcnt == PW'(DEPTH));
  assign wr_fire_o = wr_en_i & ~full_o;
  assign wbin_nx   = wbin_q + PW'(1);
  assign waddr_o   = wbin_q[AW-1:0];
  // low once count >= DEPTH - Y
  assign af_n_o    = (CW'(wcnt) + CW'(yoff_q)) < CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else if (wr_fire_o) begin
      wbin_q  <= wbin_nx;
      wgray_o <= PW'(gray_enc(32'(wbin_nx)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      yoff_q <= AW'(AF_DEF);
    else if (af_ld_i) yoff_q <= af_off_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt <= PW'(DEPTH)); // R3
  AST_FULL_IS_AF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !af_n_o); // R6
  AST_WGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1); // R2
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/100ps
module dcf_rd_ctl #(
  parameter int AW     = 9,
  parameter int AE_DEF = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [AW:0] wgray_i,
  input  logic        ae_ld_i,
  input  logic [AW-1:0] ae_off_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0] rgray_o,
  output logic        rd_fire_o,
  output logic        empty_o,
  output logic        ae_n_o
);
  import dcf_pkg::*;

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_q, rbin_nx, wbin_s, rcnt;
  logic [AW-1:0] xoff_q;

  assign wbin_s    = PW'(gray_dec(32'(wgray_i)));
  assign rcnt      = wbin_s - rbin_q;
  assign empty_o   = (rcnt == '0);
  assign rd_fire_o = rd_en_i & ~empty_o;
  assign rbin_nx   = rbin_q + PW'(1);
  assign raddr_o   = rbin_q[AW-1:0];
  assign ae_n_o    = rcnt > PW'(xoff_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else if (rd_fire_o) begin
      rbin_q  <= rbin_nx;
      rgray_o <= PW'(gray_enc(32'(rbin_nx)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      xoff_q <= AW'(AE_DEF);
    else if (ae_ld_i) xoff_q <= ae_off_i;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt <= PW'(DEPTH)); // R4
  AST_EMPTY_IS_AE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !ae_n_o); // R5
  AST_RGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1); // R2
endmodule

// File: rtl/dcfifo_almost.sv
`timescale 1ns/100ps
module dcfifo_almost #(
  parameter int AW     = 9,
  parameter int DW     = 36,
  parameter int AE_DEF = 8,
  parameter int AF_DEF = 8
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  output logic          af_n_o,
  input  logic          af_ld_i,
  input  logic [AW-1:0] af_off_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          ae_n_o,
  input  logic          ae_ld_i,
  input  logic [AW-1:0] ae_off_i
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, rd_fire;

  dcf_sync #(.W(PW)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_s)
  );

  dcf_wr_ctl #(.AW(AW), .AF_DEF(AF_DEF)) u_wr (
    .clk_i    (wclk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rgray_i  (rgray_s),
    .af_ld_i  (af_ld_i),
    .af_off_i (af_off_i),
    .waddr_o  (waddr),
    .wgray_o  (wgray),
    .wr_fire_o(wr_fire),
    .full_o   (full_o),
    .af_n_o   (af_n_o)
  );

  dcf_rd_ctl #(.AW(AW), .AE_DEF(AE_DEF)) u_rd (
    .clk_i    (rclk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .wgray_i  (wgray_s),
    .ae_ld_i  (ae_ld_i),
    .ae_off_i (ae_off_i),
    .raddr_o  (raddr),
    .rgray_o  (rgray),
    .rd_fire_o(rd_fire),
    .empty_o  (empty_o),
    .ae_n_o   (ae_n_o)
  );

  dcf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_fire),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rd_fire),
    .raddr_i(raddr),
    .q_o    (rd_data_o)
  );

  AST_EMPTY_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i) |=> $stable(rd_data_o)); // R4
endmodule

// File: tb/sim_dcfifo_almost.sv
`timescale 1ns/100ps
module sim_dcfifo_almost;
  localparam int AW    = 5;
  localparam int DW    = 36;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, af_ld = 1'b0, ae_ld = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] af_off = '0, ae_off = '0;
  logic          full_o, af_n_o, empty_o, ae_n_o;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  int x_cur = 8, y_cur = 8;
  logic [DW-1:0] q[$];

  dcfifo_almost #(.AW(AW), .DW(DW), .AE_DEF(8), .AF_DEF(8)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full_o), .af_n_o(af_n_o),
    .af_ld_i(af_ld), .af_off_i(af_off),
    .rd_en_i(rd_en), .rd_data_o(rd_data_o), .empty_o(empty_o), .ae_n_o(ae_n_o),
    .ae_ld_i(ae_ld), .ae_off_i(ae_off)
  );

  initial forever #2.5 wclk = ~wclk;          // 200 MHz
  initial begin #0.8; forever #3.5 rclk = ~rclk; end  // edges never meet wclk edges

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic logic exp_ae_n(int cnt, int x);
    return cnt > x;
  endfunction

  function automatic logic exp_af_n(int cnt, int y);
    return cnt < DEPTH - y;
  endfunction

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #1;
  endtask

  task automatic chk_flags();
    int cnt;
    cnt = q.size();
    chk("R4 empty level", empty_o, cnt == 0);
    chk("R3 full level", full_o, cnt == DEPTH);
    chk("R5 almost-empty level", ae_n_o, exp_ae_n(cnt, x_cur));
    chk("R6 almost-full level", af_n_o, exp_af_n(cnt, y_cur));
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    bit acc;
    @(negedge wclk);
    acc = !full_o;
    wr_en = 1'b1; wr_data = d;
    @(posedge wclk);
    if (acc) q.push_back(d);
    #0.1 wr_en = 1'b0;
  endtask

  task automatic rd1();
    bit acc;
    logic [DW-1:0] prev, e;
    @(negedge rclk);
    acc = !empty_o; prev = rd_data_o;
    rd_en = 1'b1;
    @(posedge rclk);
    #0.1 rd_en = 1'b0;
    #0.9;
    if (acc) begin
      e = q.pop_front();
      chk("R2 order", rd_data_o, e);
    end else chk("R4 hold on empty read", rd_data_o, prev);
  endtask

  task automatic load_x(input int v);
    @(negedge rclk); ae_ld = 1'b1; ae_off = AW'(v);
    @(posedge rclk); #0.1 ae_ld = 1'b0; x_cur = v; #1;
  endtask

  task automatic load_y(input int v);
    @(negedge wclk); af_ld = 1'b1; af_off = AW'(v);
    @(posedge wclk); #0.1 af_ld = 1'b0; y_cur = v; #1;
  endtask

  task automatic rand_phase(input int n, input int wp, input int rp);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          bit go, acc;
          logic [DW-1:0] d;
          @(negedge wclk);
          go = ($urandom_range(99) < wp);
          acc = go && !full_o;
          d = rnd_word();
          wr_en = go; wr_data = d;
          @(posedge wclk);
          if (acc) q.push_back(d);
        end
        @(negedge wclk) wr_en = 1'b0;
      end
      begin
        for (int i = 0; i < n; i++) begin
          bit go, acc;
          logic [DW-1:0] e;
          @(negedge rclk);
          go = ($urandom_range(99) < rp);
          acc = go && !empty_o;
          rd_en = go;
          @(posedge rclk);
          #1;
          if (acc) begin
            e = q.pop_front();
            chk("R2 random order", rd_data_o, e);
          end
        end
        @(negedge rclk) rd_en = 1'b0;
      end
    join
    settle();
    chk_flags();
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, e;
    void'($urandom(32'd7331));
    #20.2 rst_ni = 1'b1;
    #1;
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 ae_n", ae_n_o, 0);
    chk("R1 af_n", af_n_o, 1);
    chk("R1 rd_data", rd_data_o, 0);

    rd1();
    chk("R4 still empty", empty_o, 1);

    repeat (8) wr1(rnd_word());
    settle();
    chk_flags();
    chk("R9 default X keeps ae low at 8", ae_n_o, 0);

    // R7: write bringing count from X to X+1
    @(negedge wclk); d = rnd_word(); wr_en = 1'b1; wr_data = d;
    @(posedge wclk); q.push_back(d); #0.1 wr_en = 1'b0;
    @(posedge rclk); #1 chk("R7 ae_n after first rclk edge", ae_n_o, 0);
    @(posedge rclk); #1 chk("R7 ae_n after second rclk edge", ae_n_o, 1);

    rd1();
    chk("R5 output register counts as read", ae_n_o, 0);

    while (q.size() < DEPTH - y_cur - 1) wr1(rnd_word());
    settle();
    chk_flags();
    wr1(rnd_word());
    settle();
    chk_flags();
    chk("R9 default Y gives af low at 24", af_n_o, 0);

    // R8: read bringing count from DEPTH-Y to DEPTH-Y-1
    @(negedge rclk); rd_en = 1'b1;
    @(posedge rclk); #0.1 rd_en = 1'b0;
    @(posedge wclk); #1 chk("R8 af_n after first wclk edge", af_n_o, 0);
    @(posedge wclk); #1 chk("R8 af_n after second wclk edge", af_n_o, 1);
    e = q.pop_front();
    chk("R2 order at R8 read", rd_data_o, e);

    while (q.size() < DEPTH) wr1(rnd_word());
    settle();
    chk("R3 full reached", full_o, 1);
    wr1(36'hBAD_C0FFEE);
    settle();
    chk("R3 full after dropped write", full_o, 1);
    chk_flags();
    while (q.size() > 0) rd1();
    settle();
    chk_flags();

    repeat (4) wr1(rnd_word());
    settle();
    load_x(3);
    chk("R9 programmed X", ae_n_o, 1);
    load_y(28);
    chk("R9 programmed Y", af_n_o, 0);
    chk_flags();

    load_x(5); load_y(12);
    rand_phase(400, 75, 30);
    rand_phase(400, 30, 75);
    rand_phase(300, 50, 50);
    load_x(0); load_y(0);
    rand_phase(300, 65, 40);
    load_x(31); load_y(31);
    rand_phase(300, 45, 55);
    rand_phase(300, 80, 20);
    while (q.size() > 0) rd1();
    settle();
    chk_flags();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule